// File: doc/BRIEF.md
# DRAM Open-Page Policy Controller

This block sits between a request source and a DRAM command bus. It remembers, for each bank, whether a row is open and which row it is. Each accepted request is classified against that record as a hit on the open row, a miss on a different row, or an access to a closed bank. The block then issues the precharge, activate and column commands the access needs, with a fixed minimum spacing between them.

A two-bit page-mode setting decides what happens to the row after each access. The row can always be closed, always be left open, or be left open only while the CPU is busy. In that last mode, banks left open are also swept closed one at a time whenever the CPU reports idle and no request is waiting. A CAS-latency setting picks a read-data delay of two or three clocks. A leadoff-reduction input removes one clock from the activate-to-column gap.

Requests use a valid/ready handshake. The request is accepted on a rising edge where both are high. `req_class` reports the classification while the request is presented to an idle controller.

Top module: `dram_page_ctrl`

## Requirements
- R1: With page mode 2'b00, every column command is followed on the very next cycle by a precharge (cmd_op 3'd4) to the same bank, so the next access to that bank is classified closed.
- R2: Page mode 2'b01 behaves exactly like 2'b00: a precharge follows every column command one cycle later.
- R3: With page mode 2'b10, no precharge follows a column command. A later request to the same bank and row is classified as a hit (req_class 2'b01), and its column command issues on the cycle after acceptance, with no activate.
- R4: With page mode 2'b11, a column command is followed one cycle later by a precharge if cpu_idle is high during the column cycle; otherwise the row stays open.
- R5: With page mode 2'b11, when the controller is idle, no request is presented and cpu_idle is high, open banks are precharged one at a time, lowest bank number first. The first precharge issues on the cycle after the idle cycle, and each later one follows three cycles after the previous one.
- R6: A request to an open bank with a different row is classified as a miss (req_class 2'b10). It issues a precharge on the cycle after acceptance, an activate 2 cycles after the precharge, and the column command 2 cycles after the activate.
- R7: A request to a closed bank is classified as closed (req_class 2'b00). It issues an activate (cmd_op 3'd1, cmd_addr = row) on the cycle after acceptance and the column command (read 3'd2, write 3'd3, cmd_addr = column) 2 cycles after the activate.
- R8: With leadoff_cut high during the activate cycle, the column command follows the activate by 1 cycle instead of 2.
- R9: rd_valid pulses exactly 2 cycles after a read command when cas_sel is 2'b00, and exactly 3 cycles after it for any other cas_sel value. A write command produces no rd_valid.
- R10: After reset, req_ready is high, no command and no rd_valid are issued, and every bank is closed.
- R11: req_ready is high only in cycles without a command. A request presented while the controller is idle takes priority over an idle sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_class | output | 2 | 00 closed, 01 hit, 10 miss for the presented request |
| page_mode | input | 2 | 00/01 close, 10 keep open, 11 close when CPU idle |
| cas_sel | input | 2 | 00 gives read latency 2, otherwise 3 |
| leadoff_cut | input | 1 | Shorten the activate-to-column gap by one clock |
| cpu_idle | input | 1 | CPU idle indication, sampled each clock |
| cmd_valid | output | 1 | A command is driven this cycle |
| cmd_op | output | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ADDR_W | Row for activate, column for read/write, zero for precharge |
| rd_valid | output | 1 | Read data returns this cycle |

## Verification
The latency and policy assertions compare a command with the configuration inputs seen in the same cycle. They therefore assume that page_mode, cas_sel and leadoff_cut stay constant while an access and its read latency are in flight, and that changes happen only while the controller sits idle. The directed tests change these settings only after a settling gap of ten idle cycles. cpu_idle is the one setting that the tests change together with a request, which exercises the priority of a request over an idle sweep.

// File: rtl/dpc_pkg.sv
// Shared encodings for the open-page controller.
// Assumes: command and class codes are consumed by neighbouring logic as listed.
package dpc_pkg;
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4
    } dpc_op_e;

    typedef enum logic [1:0] {
        CL_CLOSED = 2'd0,
        CL_HIT    = 2'd1,
        CL_MISS   = 2'd2
    } dpc_class_e;
endpackage

// File: rtl/dpc_row_table.sv
// Per-bank open-row record and lookup.
// Holds one valid bit and one row register per bank. Activates set an entry,
// precharges clear it. Lookup is combinational.
// Assumes: open_we and close_we never target the same bank in one cycle.
module dpc_row_table #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic [1:0]        lk_class,
    input  logic              open_we,
    input  logic              close_we,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    output logic [NUM_BANKS-1:0] open_mask
);
    import dpc_pkg::*;

    logic [ROW_W-1:0] row_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Track open state and row of bank b.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_mask[b] <= 1'b0;
                row_q[b]     <= '0;
            end else if (open_we && upd_bank == BANK_W'(b)) begin
                open_mask[b] <= 1'b1;
                row_q[b]     <= upd_row;
            end else if (close_we && upd_bank == BANK_W'(b)) begin
                open_mask[b] <= 1'b0;
            end
        end
    end

    // Classify the looked-up address against the record.
    always_comb begin
        if (!open_mask[lk_bank])          lk_class = CL_CLOSED;
        else if (row_q[lk_bank] == lk_row) lk_class = CL_HIT;
        else                               lk_class = CL_MISS;
    end
endmodule

// File: rtl/dpc_close_policy.sv
// Page-close decision logic.
// Decides whether to close a row after an access, and whether to sweep open
// banks closed while idle. It also picks the lowest open bank for a sweep.
// Assumes: page_mode and cpu_idle are valid every cycle.
module dpc_close_policy #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [1:0]           page_mode,
    input  logic                 cpu_idle,
    input  logic [NUM_BANKS-1:0] open_mask,
    output logic                 close_after,
    output logic                 sweep_req,
    output logic [BANK_W-1:0]    sweep_bank
);
    logic idle_mode;
    assign idle_mode = (page_mode == 2'b11);

    // Modes 00/01 always close; 11 closes when idle; 10 keeps the row open.
    always_comb close_after = !page_mode[1] || (idle_mode && cpu_idle);

    // Request an idle sweep while any bank is open.
    always_comb sweep_req = idle_mode && cpu_idle && (|open_mask);

    // Priority pick of the lowest open bank.
    always_comb begin
        sweep_bank = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (open_mask[b]) sweep_bank = BANK_W'(b);
        end
    end
endmodule

// File: rtl/dpc_rd_pipe.sv
// Read-return timing pipe.
// Delays a read-issue pulse by a short or a long CAS latency, chosen by cas_sel.
// Assumes: cas_sel is stable while reads are in flight.
module dpc_rd_pipe #(
    parameter int LAT_SHORT = 2,
    parameter int LAT_LONG  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_issue,
    input  logic [1:0] cas_sel,
    output logic       rd_valid
);
    logic [LAT_LONG-1:0] stage_q;

    // Shift read pulses down the latency line.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[LAT_LONG-2:0], rd_issue};
    end

    // Tap the stage that matches the selected latency.
    always_comb rd_valid = (cas_sel == 2'b00) ? stage_q[LAT_SHORT-1] : stage_q[LAT_LONG-1];
endmodule

// File: rtl/dram_page_ctrl.sv
// DRAM open-page policy controller (top).
// Accepts one request at a time. It classifies the request against the per-bank
// open rows and sequences precharge, activate and column commands with minimum
// gaps T_RP and T_RCD. After the access it applies the page policy.
// Assumes: configuration inputs change only while the controller is idle.
module dram_page_ctrl #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 8,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic [1:0]        req_class,
    input  logic [1:0]        page_mode,
    input  logic [1:0]        cas_sel,
    input  logic              leadoff_cut,
    input  logic              cpu_idle,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              rd_valid
);
    import dpc_pkg::*;

    localparam int GAP_MAX = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int CW      = $clog2(GAP_MAX + 1) + 1;

    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_ACT, S_WAIT, S_COL, S_CLOSE, S_SWEEP
    } st_e;

    st_e               state, tgt;
    logic [CW-1:0]     cnt;
    logic [BANK_W-1:0] cur_bank;
    logic [ROW_W-1:0]  cur_row;
    logic [COL_W-1:0]  cur_col;
    logic              cur_wr;
    logic [NUM_BANKS-1:0] open_mask;
    logic              close_after, sweep_req;
    logic [BANK_W-1:0] sweep_bank;
    logic [CW-1:0]     rcd_gap;

    dpc_row_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .lk_bank(req_bank), .lk_row(req_row), .lk_class(req_class),
        .open_we(state == S_ACT),
        .close_we(state == S_PRE || state == S_CLOSE || state == S_SWEEP),
        .upd_bank(cur_bank), .upd_row(cur_row), .open_mask(open_mask)
    );

    dpc_close_policy #(.NUM_BANKS(NUM_BANKS)) u_policy (
        .page_mode(page_mode), .cpu_idle(cpu_idle), .open_mask(open_mask),
        .close_after(close_after), .sweep_req(sweep_req), .sweep_bank(sweep_bank)
    );

    dpc_rd_pipe #(.LAT_SHORT(2), .LAT_LONG(3)) u_rdpipe (
        .clk(clk), .rst_n(rst_n), .rd_issue(cmd_op == OP_RD),
        .cas_sel(cas_sel), .rd_valid(rd_valid)
    );

    // Activate-to-column gap, shortened by one when leadoff reduction is on.
    always_comb rcd_gap = CW'(T_RCD) - CW'(leadoff_cut);

    // Command sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            tgt      <= S_IDLE;
            cnt      <= '0;
            cur_bank <= '0;
            cur_row  <= '0;
            cur_col  <= '0;
            cur_wr   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        cur_bank <= req_bank;
                        cur_row  <= req_row;
                        cur_col  <= req_col;
                        cur_wr   <= req_write;
                        case (req_class)
                            CL_HIT:  state <= S_COL;
                            CL_MISS: state <= S_PRE;
                            default: state <= S_ACT;
                        endcase
                    end else if (sweep_req) begin
                        cur_bank <= sweep_bank;
                        state    <= S_SWEEP;
                    end
                end
                S_PRE: begin
                    if (T_RP > 1) begin
                        cnt <= CW'(T_RP - 1); tgt <= S_ACT; state <= S_WAIT;
                    end else state <= S_ACT;
                end
                S_ACT: begin
                    if (rcd_gap > CW'(1)) begin
                        cnt <= rcd_gap - CW'(1); tgt <= S_COL; state <= S_WAIT;
                    end else state <= S_COL;
                end
                S_COL:   state <= close_after ? S_CLOSE : S_IDLE;
                S_CLOSE, S_SWEEP: begin
                    if (T_RP > 1) begin
                        cnt <= CW'(T_RP - 1); tgt <= S_IDLE; state <= S_WAIT;
                    end else state <= S_IDLE;
                end
                S_WAIT: begin
                    if (cnt <= CW'(1)) state <= tgt;
                    else               cnt   <= cnt - CW'(1);
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive the command bus from the current state.
    always_comb begin
        cmd_op   = OP_NOP;
        cmd_addr = '0;
        case (state)
            S_ACT: begin cmd_op = OP_ACT; cmd_addr = ADDR_W'(cur_row); end
            S_COL: begin cmd_op = cur_wr ? OP_WR : OP_RD; cmd_addr = ADDR_W'(cur_col); end
            S_PRE, S_CLOSE, S_SWEEP: cmd_op = OP_PRE;
            default: ;
        endcase
    end

    assign cmd_bank  = cur_bank;
    assign cmd_valid = (cmd_op != OP_NOP);
    assign req_ready = (state == S_IDLE);

    // ---------------- assertions ----------------
    logic col_cmd;
    assign col_cmd = (cmd_op == OP_RD) || (cmd_op == OP_WR);

    // R1 and R2: modes 00/01 precharge the same bank right after a column command.
    a_r1_close_after_col: assert property (@(posedge clk) disable iff (!rst_n)
        (col_cmd && !page_mode[1]) |=> (cmd_op == OP_PRE && cmd_bank == $past(cmd_bank)));

    a_r3_row_kept_open: assert property (@(posedge clk) disable iff (!rst_n)
        (col_cmd && page_mode == 2'b10) |=> (cmd_op != OP_PRE));

    a_r4_close_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (col_cmd && page_mode == 2'b11) |=> ((cmd_op == OP_PRE) == $past(cpu_idle)));

    a_r6_precharge_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_PRE) |=> (cmd_op != OP_ACT));

    a_r7_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_ACT && !leadoff_cut) |=> !col_cmd);

    a_r9_cas_short: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_RD && cas_sel == 2'b00) |-> ##2 rd_valid);

    a_r9_cas_long: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_RD && cas_sel != 2'b00) |-> ##3 rd_valid);

    a_r11_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid);
endmodule

// File: tb/dram_page_ctrl_bench.sv
module dram_page_ctrl_bench;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_bank = '0;
    logic [11:0] req_row = '0;
    logic [7:0] req_col = '0;
    logic [1:0] page_mode = 2'b10, cas_sel = 2'b00;
    logic leadoff_cut = 1'b0, cpu_idle = 1'b0;
    logic req_ready, cmd_valid, rd_valid;
    logic [1:0] req_class, cmd_bank;
    logic [2:0] cmd_op;
    logic [11:0] cmd_addr;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int n_log = 0, rdv_cnt = 0, rdv_cyc = -1;
    int lop [16], lcyc [16], lbank [16], laddr [16];
    bit done = 0;

    dram_page_ctrl u_dram_page_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_class(req_class), .page_mode(page_mode),
        .cas_sel(cas_sel), .leadoff_cut(leadoff_cut), .cpu_idle(cpu_idle),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .rd_valid(rd_valid)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Command and read-return monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid && n_log < 16) begin
                lop[n_log] = int'(cmd_op); lcyc[n_log] = cyc;
                lbank[n_log] = int'(cmd_bank); laddr[n_log] = int'(cmd_addr);
                n_log++;
            end
            if (rd_valid) begin rdv_cnt++; rdv_cyc = cyc; end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_log();
        n_log = 0; rdv_cnt = 0; rdv_cyc = -1;
        for (int i = 0; i < 16; i++) begin lop[i] = -1; lcyc[i] = -1; lbank[i] = -1; laddr[i] = -1; end
    endtask

    // Present one request, return the acceptance cycle and class, then let it settle.
    task automatic issue(int b, int r, int c, bit wr, bit idle_v, output int acc, output int cls,
                         output int rdy_after);
        clr_log();
        @(negedge clk);
        req_valid = 1'b1; req_bank = 2'(b); req_row = 12'(r); req_col = 8'(c);
        req_write = wr; cpu_idle = idle_v;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        acc = cyc; cls = int'(req_class);
        @(negedge clk);
        rdy_after = int'(req_ready);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 ready after reset", int'(req_ready), 1);
        chk("R10 no command after reset", int'(cmd_valid), 0);
        chk("R10 no rd_valid after reset", int'(rd_valid), 0);
    endtask

    task automatic t_closed_read();
        int a, c, r;
        page_mode = 2'b10; cas_sel = 2'b00;
        issue(0, 5, 3, 1'b0, 1'b0, a, c, r);
        chk("R10 R7 class closed", c, 0);
        chk("R7 command count", n_log, 2);
        chk("R7 act op", lop[0], 1);  chk("R7 act cycle", lcyc[0], a + 1);
        chk("R7 act row", laddr[0], 5);
        chk("R7 rd op", lop[1], 2);   chk("R7 rd cycle", lcyc[1], a + 3);
        chk("R7 rd col", laddr[1], 3);
        chk("R9 cl2 cycle", rdv_cyc, a + 5); chk("R9 cl2 count", rdv_cnt, 1);
    endtask

    task automatic t_hit_write();
        int a, c, r;
        issue(0, 5, 7, 1'b1, 1'b0, a, c, r);
        chk("R3 class hit", c, 1);
        chk("R3 only column command", n_log, 1);
        chk("R3 wr op", lop[0], 3); chk("R3 wr cycle", lcyc[0], a + 1);
        chk("R9 write has no rd_valid", rdv_cnt, 0);
    endtask

    task automatic t_miss_read();
        int a, c, r;
        cas_sel = 2'b01;
        issue(0, 9, 1, 1'b0, 1'b0, a, c, r);
        chk("R6 class miss", c, 2);
        chk("R11 ready low while busy", r, 0);
        chk("R6 pre op", lop[0], 4);   chk("R6 pre cycle", lcyc[0], a + 1);
        chk("R6 act op", lop[1], 1);   chk("R6 act cycle", lcyc[1], a + 3);
        chk("R6 act row", laddr[1], 9);
        chk("R6 rd cycle", lcyc[2], a + 5);
        chk("R9 cl3 cycle", rdv_cyc, a + 8);
        cas_sel = 2'b00;
    endtask

    task automatic t_close_00();
        int a, c, r;
        page_mode = 2'b00; leadoff_cut = 1'b1;
        issue(1, 4, 2, 1'b0, 1'b0, a, c, r);
        chk("R8 act cycle", lcyc[0], a + 1);
        chk("R8 rd after one cycle", lcyc[1], a + 2);
        chk("R1 pre op", lop[2], 4); chk("R1 pre cycle", lcyc[2], a + 3);
        chk("R1 pre bank", lbank[2], 1);
        leadoff_cut = 1'b0;
        issue(1, 4, 2, 1'b0, 1'b0, a, c, r);
        chk("R1 bank closed after access", c, 0);
    endtask

    task automatic t_close_01();
        int a, c, r;
        page_mode = 2'b01;
        issue(2, 6, 0, 1'b1, 1'b0, a, c, r);
        chk("R2 wr cycle", lcyc[1], a + 3);
        chk("R2 pre op", lop[2], 4); chk("R2 pre cycle", lcyc[2], a + 4);
        chk("R2 pre bank", lbank[2], 2);
    endtask

    task automatic t_idle_mode();
        int a, c, r, c0;
        page_mode = 2'b11;
        issue(3, 7, 0, 1'b0, 1'b0, a, c, r);
        chk("R4 busy cpu keeps row open", n_log, 2);
        // Idle sweep: bank 0 (row 9) and bank 3 (row 7) are open.
        clr_log();
        @(negedge clk);
        c0 = cyc; cpu_idle = 1'b1;
        repeat (10) @(negedge clk);
        chk("R5 sweep count", n_log, 2);
        chk("R5 first pre op", lop[0], 4);  chk("R5 first pre bank", lbank[0], 0);
        chk("R5 first pre cycle", lcyc[0], c0 + 1);
        chk("R5 second pre bank", lbank[1], 3);
        chk("R5 second pre cycle", lcyc[1], c0 + 4);
        cpu_idle = 1'b0;
        issue(0, 9, 4, 1'b0, 1'b0, a, c, r);
        chk("R5 swept bank closed", c, 0);
        // Request and idle arrive together: request wins, then row closes.
        issue(0, 9, 5, 1'b0, 1'b1, a, c, r);
        chk("R11 request beats sweep class", c, 1);
        chk("R11 request beats sweep rd", lop[0], 2);
        chk("R4 rd cycle", lcyc[0], a + 1);
        chk("R4 idle pre op", lop[1], 4);
        chk("R4 idle pre cycle", lcyc[1], a + 2);
        cpu_idle = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_closed_read();
        t_hit_write();
        t_miss_read();
        t_close_00();
        t_close_01();
        t_idle_mode();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule